// File: doc/BRIEF.md
# Round-Robin Converter Multiplexing Scheduler

This block lets one analog-to-digital converter serve several delay channels in turn. Its timing comes only from the converter's completion signal and from a word-time tick, and it ignores each channel's own sampling rate. It keeps three pointers. The input index selects the channel that the converter samples next. The one-hot output ring selects the channel buffer that receives the current result. The DAC selection index selects which channel's stored point is moved to its converter output next.

When the converter finishes, the block makes one single-cycle pulse from the rising edge of the done line. That pulse moves the input index forward at once and marks a finished result. At the next word-time tick the block opens a data window that lasts exactly one word time, and the selected buffer latches the result during that window. When the window closes, a step request is held. The ring and the DAC index advance together on that step, unless a DAC load is in progress. A new conversion start is issued a fixed number of settling cycles after each input-index change, and also after reset.

The input index therefore runs one channel ahead of the output ring for most of each sequence. Channel logic that uses the ring must take this into account.

Top module: `conv_rr_sched`

## Requirements
- R1: While reset is asserted, and right after it, the input index and the DAC index are 0, ring bit 0 alone is set, and the data window and the ring step are low.
- R2: A rising edge on `conv_done` advances `in_idx` by one, modulo NUM_CH, by the next clock.
- R3: The data window opens only on a clock edge that samples `word_tick` high after a rising edge on `conv_done`. It stays high until the next clock edge that samples `word_tick` high, and then closes.
- R4: `ring_step` goes high only after a data window has closed, and only once for each window.
- R5: Each `ring_step` rotates the ring by one position toward the higher bit and advances `dac_idx` by one, both by the next clock. `ring_sel` always has exactly one bit set.
- R6: While `dac_busy` is high, `ring_step` stays low and the ring and `dac_idx` hold. When `dac_busy` falls, the held step is issued.
- R7: `conv_start` is a single-cycle pulse. It is sampled high SETTLE_CYC clock cycles after the edge that moved `in_idx` (or after reset release).
- R8: Both indices wrap from NUM_CH-1 to 0, and the ring wraps from bit NUM_CH-1 to bit 0.
- R9: Holding `conv_done` high over several clocks advances `in_idx` only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Converter completion level |
| word_tick | input | 1 | One-cycle pulse at each serial word boundary |
| dac_busy | input | 1 | DAC load in progress; stalls ring stepping |
| conv_start | output | 1 | Start pulse for the next conversion |
| in_idx | output | IDX_W | Channel selected at the converter input |
| ring_sel | output | NUM_CH | One-hot select of the buffer receiving the result |
| data_win | output | 1 | One-word-time result load window |
| ring_step | output | 1 | Pulse stepping the ring and the DAC index |
| dac_idx | output | IDX_W | Channel selected for the next DAC load |

## Verification
A corrupted input index sends the next sample to the wrong channel. This shows on `in_idx` one clock after the done edge. A ring with a lost bit or a duplicated bit shows on `ring_sel` at the next step, and the one-hot checks catch it in the same cycle. An error in the window or step sequencing shows within one word time. Either the window has the wrong length, or `ring_step` fires while `dac_busy` is high, or it never fires, so the ring and `dac_idx` do not match the bench's own count of steps.

// File: rtl/conv_rr_pkg.sv
package conv_rr_pkg;
   localparam int MAX_CH = 10;

   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic int cnt_width(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/rr_wrap_counter.sv
module rr_wrap_counter #(
   parameter int N = 10,
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] idx_o
);
   localparam logic [W-1:0] LAST = W'(N - 1);

   generate
      if (N == 1) begin : g_single
         assign idx_o = '0;
      end else begin : g_multi
         logic [W-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      idx_q <= '0;
            else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
         end
         assign idx_o = idx_q;

         a_r2_advance : assert property (@(posedge clk) disable iff (!rst_n)
            step_i |=> idx_o == (($past(idx_o) == LAST) ? '0 : $past(idx_o) + 1'b1));
         a_r8_in_range : assert property (@(posedge clk) disable iff (!rst_n)
            idx_o <= LAST);
      end
   endgenerate
endmodule

// File: rtl/rr_onehot_ring.sv
module rr_onehot_ring #(
   parameter int N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [N-1:0] sel_o
);
   generate
      if (N == 1) begin : g_single
         assign sel_o = 1'b1;
      end else begin : g_multi
         logic [N-1:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_q <= N'(1);
            else if (step_i) sel_q <= {sel_q[N-2:0], sel_q[N-1]};
         end
         assign sel_o = sel_q;

         a_r5_rotate : assert property (@(posedge clk) disable iff (!rst_n)
            step_i |=> sel_o == {$past(sel_o[N-2:0]), $past(sel_o[N-1])});
      end
   endgenerate

   a_r5_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_o) == 1);
endmodule

// File: rtl/rr_settle_timer.sv
module rr_settle_timer #(
   parameter int SETTLE = 3,
   parameter int CW     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   output logic start_o
);
   logic          armed_q;
   logic [CW-1:0] cnt_q;

   assign start_o = armed_q && (cnt_q == CW'(SETTLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (start_o) begin
         armed_q <= 1'b0;
      end else if (armed_q) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   a_r7_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && !arm_i) |=> !start_o);
   a_r7_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(SETTLE));
endmodule

// File: rtl/rr_window_seq.sv
module rr_window_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic fin_set_i,
   input  logic word_tick_i,
   input  logic dac_busy_i,
   output logic win_o,
   output logic step_o
);
   logic fin_q, win_q, pend_q;
   logic open_w, close_w;

   assign open_w  = fin_q && word_tick_i && !win_q;
   assign close_w = win_q && word_tick_i;
   assign win_o   = win_q;
   assign step_o  = pend_q && !dac_busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fin_q  <= 1'b0;
         win_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (fin_set_i)   fin_q <= 1'b1;
         else if (open_w) fin_q <= 1'b0;

         if (close_w)     win_q <= 1'b0;
         else if (open_w) win_q <= 1'b1;

         if (close_w)     pend_q <= 1'b1;
         else if (step_o) pend_q <= 1'b0;
      end
   end

   a_r3_open_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_o) |-> $past(word_tick_i));
   a_r3_hold_window : assert property (@(posedge clk) disable iff (!rst_n)
      (win_o && !word_tick_i) |=> win_o);
   a_r6_busy_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && dac_busy_i) |=> pend_q);
   a_r4_step_once : assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !close_w) |=> !step_o);
endmodule

// File: rtl/conv_rr_sched.sv
module conv_rr_sched #(
   parameter int NUM_CH     = 10,
   parameter int SETTLE_CYC = 3,
   parameter int IDX_W      = conv_rr_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic              word_tick,
   input  logic              dac_busy,
   output logic              conv_start,
   output logic [IDX_W-1:0]  in_idx,
   output logic [NUM_CH-1:0] ring_sel,
   output logic              data_win,
   output logic              ring_step,
   output logic [IDX_W-1:0]  dac_idx
);
   localparam int CNT_W = conv_rr_pkg::cnt_width(SETTLE_CYC);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= conv_rr_pkg::MAX_CH)
         else $error("NUM_CH out of range");
      assert (SETTLE_CYC >= 0) else $error("SETTLE_CYC negative");
      assert (IDX_W >= conv_rr_pkg::idx_width(NUM_CH)) else $error("IDX_W too small");
   end

   logic done_q;
   logic done_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= conv_done;
   end
   assign done_pulse = conv_done && !done_q;

   rr_wrap_counter #(.N(NUM_CH), .W(IDX_W)) u_in_cnt (
      .clk(clk), .rst_n(rst_n), .step_i(done_pulse), .idx_o(in_idx));

   rr_settle_timer #(.SETTLE(SETTLE_CYC), .CW(CNT_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .arm_i(done_pulse), .start_o(conv_start));

   rr_window_seq u_seq (
      .clk(clk), .rst_n(rst_n), .fin_set_i(done_pulse), .word_tick_i(word_tick),
      .dac_busy_i(dac_busy), .win_o(data_win), .step_o(ring_step));

   rr_onehot_ring #(.N(NUM_CH)) u_ring (
      .clk(clk), .rst_n(rst_n), .step_i(ring_step), .sel_o(ring_sel));

   rr_wrap_counter #(.N(NUM_CH), .W(IDX_W)) u_dac_cnt (
      .clk(clk), .rst_n(rst_n), .step_i(ring_step), .idx_o(dac_idx));

   a_r6_ring_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      dac_busy |=> (ring_sel == $past(ring_sel)) && (dac_idx == $past(dac_idx)));
   a_r9_level_no_advance : assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && $past(conv_done)) |=> in_idx == $past(in_idx));
   a_r5_ring_tracks_dac : assert property (@(posedge clk) disable iff (!rst_n)
      ring_sel[dac_idx] == 1'b1);
endmodule

// File: tb/test_conv_rr_sched.sv
module test_conv_rr_sched;
   localparam int N  = 5;
   localparam int S  = 3;
   localparam int IW = 3;
   localparam int NV = 12;
   // each row: {ticks of gap before window, extra cycles inside window, busy cycles}
   localparam int VEC [NV][3] = '{
      '{0, 2, 0}, '{1, 0, 0}, '{3, 4, 2}, '{0, 1, 5},
      '{2, 3, 0}, '{0, 0, 1}, '{4, 2, 3}, '{1, 5, 0},
      '{0, 1, 0}, '{2, 0, 4}, '{1, 1, 1}, '{3, 3, 0}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic conv_done = 1'b0, word_tick = 1'b0, dac_busy = 1'b0;
   logic conv_start, data_win, ring_step;
   logic [IW-1:0] in_idx, dac_idx;
   logic [N-1:0]  ring_sel;

   int checks = 0, failures = 0;
   int exp_in = 0, exp_ring = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   conv_rr_sched #(.NUM_CH(N), .SETTLE_CYC(S), .IDX_W(IW)) i_conv_rr_sched (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .word_tick(word_tick),
      .dac_busy(dac_busy), .conv_start(conv_start), .in_idx(in_idx),
      .ring_sel(ring_sel), .data_win(data_win), .ring_step(ring_step),
      .dac_idx(dac_idx));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] ring_of(input int p);
      logic [N-1:0] v = '0;
      v[p] = 1'b1;
      return v;
   endfunction

   task automatic chk_reset_state(input string tag);
      chk(in_idx == 0 && dac_idx == 0, tag, int'(in_idx), 0);
      chk(ring_sel == ring_of(0), tag, int'(ring_sel), 1);
      chk(!data_win && !ring_step, tag, int'(data_win), 0);
   endtask

   task automatic run_conv(input int gap, input int wl, input int busy);
      bit ok;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      exp_in = (exp_in + 1) % N;
      chk(int'(in_idx) == exp_in, "R2/R8 input index", int'(in_idx), exp_in);
      ok = 1;
      for (int i = 0; i <= S; i++) begin
         if (conv_start !== (i == S)) ok = 0;
         if (i < S) @(negedge clk);
      end
      chk(ok, "R7 start after settle", int'(ok), 1);
      repeat (gap) @(negedge clk);
      chk(!data_win, "R3 no window before tick", int'(data_win), 0);
      word_tick = 1'b1;
      @(negedge clk);
      word_tick = 1'b0;
      chk(data_win, "R3 window opens", int'(data_win), 1);
      dac_busy = (busy > 0);
      ok = 1;
      for (int i = 0; i < wl; i++) begin
         @(negedge clk);
         if (!data_win || ring_step) ok = 0;
      end
      chk(ok, "R3/R4 window held, no step", int'(ok), 1);
      word_tick = 1'b1;
      @(negedge clk);
      word_tick = 1'b0;
      chk(!data_win, "R3 window closes", int'(data_win), 0);
      ok = 1;
      for (int i = 0; i < busy; i++) begin
         if (ring_step || ring_sel != ring_of(exp_ring) || int'(dac_idx) != exp_ring) ok = 0;
         @(negedge clk);
      end
      chk(ok, "R6 busy stalls ring", int'(ok), 1);
      dac_busy = 1'b0;
      #0;
      chk(ring_step, "R4 step after window", int'(ring_step), 1);
      @(negedge clk);
      exp_ring = (exp_ring + 1) % N;
      chk(ring_sel == ring_of(exp_ring), "R5/R8 ring rotated", int'(ring_sel), int'(ring_of(exp_ring)));
      chk(int'(dac_idx) == exp_ring, "R5/R8 dac index", int'(dac_idx), exp_ring);
      chk(!ring_step, "R4 single step", int'(ring_step), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_reset_state("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset_state("R1 after release");
      repeat (S + 3) @(negedge clk);
      for (int v = 0; v < NV; v++) run_conv(VEC[v][0], VEC[v][1], VEC[v][2]);
      // R9: level held high gives one advance only
      conv_done = 1'b1;
      repeat (4) @(negedge clk);
      conv_done = 1'b0;
      exp_in = (exp_in + 1) % N;
      chk(int'(in_idx) == exp_in, "R9 held done advances once", int'(in_idx), exp_in);
      repeat (S + 2) @(negedge clk);
      // mid-run reset returns to the R1 state
      rst_n = 1'b0;
      @(negedge clk);
      chk_reset_state("R1 mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule